// File: doc/BRIEF.md
# Inbound Read Error Response Controller

This block decides how an inbound read that met a parity error on the internal bus is reported back to the external requester. A mode input selects one of two responses. In conventional mode, the block remembers which data beat of the current request was the first to arrive with bad parity. It lets every earlier beat go out normally. When that same beat is handed to the external bus, it requests a target abort for exactly one cycle. It also sets a sticky status bit and, unless masked, an interrupt-status bit. Once the completion cycle has finished, it pulses a flush of the inbound read queue. In split-transaction mode, it raises a split completion error message request instead. That request carries the completer-error class and the internal-target-abort index, and it is held until acknowledged. The block also sets a second interrupt-status bit unless that bit is masked.

The surrounding target logic marks the start of each request with `req_start_i`. It reports each internal beat as it arrives, together with its parity flag. It reports each beat handed to the external bus with its index, and it pulses `cmpl_done_i` when the external completion finishes. Software-side logic clears the sticky bits through write-one-to-clear strobes. The actual bus signalling is done elsewhere.

Top module: `ibrd_err_resp`

## Requirements
- R1: After reset, `abort_o`, `flush_o` and `msg_req_o` are low, `msg_class_o` and `msg_index_o` are zero, and `status_o` and `irq_stat_o` are all zero.
- R2: In conventional mode (`split_mode_i`=0), `abort_o` is high for exactly one cycle. That cycle is the one after the cycle in which `ret_vld_i` is high with `ret_idx_i` equal to the index of the latched bad beat. Beats returned before that one cause no abort.
- R3: Only the first beat of a request reported with `ib_perr_i`=1 is latched. Later bad beats of the same request cause no further abort.
- R4: Status bit 11 (`status_o[11]`) becomes 1 in the same cycle that `abort_o` is high.
- R5: `irq_stat_o[0]` (target-abort interrupt) is set together with the abort only when `mask_ta_i` is 0. When `mask_ta_i` is 1 it is left unchanged.
- R6: `flush_o` pulses for one cycle, in the cycle after `cmpl_done_i`, and only for a request that signalled an abort.
- R7: In split mode, a bad beat raises `msg_req_o` in the next cycle with `msg_class_o`=4'h2 and `msg_index_o`=8'h81. The request, class and index are held until `msg_ack_i`, after which `msg_req_o` is low in the following cycle. No abort is signalled in split mode.
- R8: `irq_stat_o[1]` (initiated error message interrupt) is set when a message is started, only if `mask_msg_i` is 0.
- R9: While a message is pending, further bad beats are ignored. They do not cause a second message after the acknowledge.
- R10: Status and interrupt-status bits are sticky and are cleared by a 1 in the matching bit of `stat_w1c_i` / `irq_w1c_i`. A set and a clear of the same bit in the same cycle leave it set.
- R11: A request with no bad beat produces no abort, message or flush, and no status or interrupt-status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_mode_i | input | 1 | 1 = split-transaction mode, 0 = conventional mode |
| req_start_i | input | 1 | First cycle of a new inbound read request |
| ib_vld_i | input | 1 | An internal-bus data beat arrives |
| ib_idx_i | input | BEAT_W | Index of the arriving internal beat |
| ib_perr_i | input | 1 | The arriving beat has a parity error |
| ret_vld_i | input | 1 | A beat is being returned on the external bus |
| ret_idx_i | input | BEAT_W | Index of the returned beat |
| cmpl_done_i | input | 1 | External completion cycle finished |
| msg_ack_i | input | 1 | Error message has been issued |
| mask_ta_i | input | 1 | Mask for the target-abort interrupt bit |
| mask_msg_i | input | 1 | Mask for the error-message interrupt bit |
| stat_w1c_i | input | STAT_W | Write-one-to-clear strobes for `status_o` |
| irq_w1c_i | input | 2 | Write-one-to-clear strobes for `irq_stat_o` |
| abort_o | output | 1 | Target abort request on the current beat |
| flush_o | output | 1 | Flush the inbound read queue |
| msg_req_o | output | 1 | Split completion error message request |
| msg_class_o | output | 4 | Message class while requested |
| msg_index_o | output | 8 | Message index while requested |
| status_o | output | STAT_W | Sticky status register |
| irq_stat_o | output | 2 | Sticky interrupt-status bits (0 abort, 1 message) |

## Verification
The main function is driven with four patterns. A clean request tells apart a responder that reacts to any traffic from one that reacts only to parity errors. A request with two bad beats, returned in order, shows whether the abort waits for the failing beat and whether only the first bad beat counts. A masked request, with a clear strobe landing on the abort cycle, separates the masked and unmasked interrupt paths and shows whether a set or a clear wins. A split-mode request with a second error while the message is pending shows whether the message is held, whether its code is correct, and whether the extra error leaks through after the acknowledge.

// File: rtl/ibrd_pkg.sv
package ibrd_pkg;

   localparam int unsigned CLASS_W = 4;
   localparam int unsigned INDEX_W = 8;

   // completer-error class and internal-target-abort index of the error message
   localparam logic [CLASS_W-1:0] CLS_COMPLETER = 4'h2;
   localparam logic [INDEX_W-1:0] IDX_INT_ABORT = 8'h81;

   typedef enum int unsigned {
      IRQ_TA  = 0,
      IRQ_MSG = 1,
      IRQ_NUM = 2
   } irq_pos_e;

   localparam int unsigned IRQ_W = IRQ_NUM;

endpackage

// File: rtl/ibrd_err_track.sv
module ibrd_err_track #(
   parameter int unsigned BEAT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              new_req_i,
   input  logic              drop_i,
   input  logic              hit_i,
   input  logic [BEAT_W-1:0] hit_idx_i,
   output logic              err_vld_o,
   output logic [BEAT_W-1:0] err_idx_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_vld_o <= 1'b0;
         err_idx_o <= '0;
      end else if (new_req_i) begin
         // a beat in the start cycle already belongs to the new request
         err_vld_o <= hit_i;
         err_idx_o <= hit_i ? hit_idx_i : '0;
      end else if (drop_i) begin
         err_vld_o <= 1'b0;
      end else if (hit_i && !err_vld_o) begin
         err_vld_o <= 1'b1;
         err_idx_o <= hit_idx_i;
      end
   end

endmodule

// File: rtl/ibrd_abort_gen.sv
module ibrd_abort_gen #(
   parameter int unsigned BEAT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              new_req_i,
   input  logic              cmpl_done_i,
   input  logic              err_vld_i,
   input  logic [BEAT_W-1:0] err_idx_i,
   input  logic              ret_vld_i,
   input  logic [BEAT_W-1:0] ret_idx_i,
   output logic              ta_set_o,
   output logic              abort_o,
   output logic              flush_o
);

   logic aborted_q;
   logic hit_beat;

   assign hit_beat = ret_vld_i && err_vld_i && (ret_idx_i == err_idx_i) && !aborted_q;
   assign ta_set_o = hit_beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aborted_q <= 1'b0;
         abort_o   <= 1'b0;
         flush_o   <= 1'b0;
      end else begin
         abort_o <= hit_beat;
         flush_o <= cmpl_done_i && aborted_q;
         if (new_req_i || cmpl_done_i) begin
            aborted_q <= 1'b0;
         end else if (hit_beat) begin
            aborted_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ibrd_msg_gen.sv
module ibrd_msg_gen #(
   parameter int unsigned CLASS_W = 4,
   parameter int unsigned INDEX_W = 8,
   parameter logic [CLASS_W-1:0] MSG_CLASS = '0,
   parameter logic [INDEX_W-1:0] MSG_INDEX = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               err_i,
   input  logic               ack_i,
   output logic               init_o,
   output logic               req_o,
   output logic [CLASS_W-1:0] class_o,
   output logic [INDEX_W-1:0] index_o
);

   logic pend_q;

   assign init_o  = err_i && !pend_q;
   assign req_o   = pend_q;
   assign class_o = pend_q ? MSG_CLASS : '0;
   assign index_o = pend_q ? MSG_INDEX : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (init_o) begin
         pend_q <= 1'b1;
      end else if (ack_i) begin
         pend_q <= 1'b0;
      end
   end

endmodule

// File: rtl/ibrd_w1c_reg.sv
module ibrd_w1c_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] q_o
);

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_o[b] <= 1'b0;
         end else begin
            // set has priority over a clear in the same cycle
            q_o[b] <= set_i[b] | (q_o[b] & ~clr_i[b]);
         end
      end
   end

endmodule

// File: rtl/ibrd_err_resp.sv
module ibrd_err_resp
   import ibrd_pkg::*;
#(
   parameter int unsigned BEAT_W = 4,
   parameter int unsigned STAT_W = 16,
   parameter int unsigned TA_BIT = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                split_mode_i,
   input  logic                req_start_i,
   input  logic                ib_vld_i,
   input  logic [BEAT_W-1:0]   ib_idx_i,
   input  logic                ib_perr_i,
   input  logic                ret_vld_i,
   input  logic [BEAT_W-1:0]   ret_idx_i,
   input  logic                cmpl_done_i,
   input  logic                msg_ack_i,
   input  logic                mask_ta_i,
   input  logic                mask_msg_i,
   input  logic [STAT_W-1:0]   stat_w1c_i,
   input  logic [IRQ_W-1:0]    irq_w1c_i,
   output logic                abort_o,
   output logic                flush_o,
   output logic                msg_req_o,
   output logic [CLASS_W-1:0]  msg_class_o,
   output logic [INDEX_W-1:0]  msg_index_o,
   output logic [STAT_W-1:0]   status_o,
   output logic [IRQ_W-1:0]    irq_stat_o
);

   localparam int unsigned IRQ_TA_POS  = int'(IRQ_TA);
   localparam int unsigned IRQ_MSG_POS = int'(IRQ_MSG);

   if (BEAT_W < 1) begin : g_bad_beat_w
      $error("BEAT_W must be at least 1");
   end
   if (TA_BIT >= STAT_W) begin : g_bad_ta_bit
      $error("TA_BIT must lie inside the status register");
   end

   logic bad_beat;
   logic conv_hit;
   logic split_hit;
   logic err_vld;
   logic [BEAT_W-1:0] err_idx;
   logic ta_set;
   logic msg_init;
   logic [STAT_W-1:0] stat_set;
   logic [IRQ_W-1:0]  irq_set;

   assign bad_beat  = ib_vld_i && ib_perr_i;
   assign conv_hit  = bad_beat && !split_mode_i;
   assign split_hit = bad_beat && split_mode_i;

   ibrd_err_track #(.BEAT_W(BEAT_W)) trk_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .new_req_i (req_start_i),
      .drop_i    (cmpl_done_i),
      .hit_i     (conv_hit),
      .hit_idx_i (ib_idx_i),
      .err_vld_o (err_vld),
      .err_idx_o (err_idx)
   );

   ibrd_abort_gen #(.BEAT_W(BEAT_W)) abt_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .new_req_i   (req_start_i),
      .cmpl_done_i (cmpl_done_i),
      .err_vld_i   (err_vld),
      .err_idx_i   (err_idx),
      .ret_vld_i   (ret_vld_i),
      .ret_idx_i   (ret_idx_i),
      .ta_set_o    (ta_set),
      .abort_o     (abort_o),
      .flush_o     (flush_o)
   );

   ibrd_msg_gen #(
      .CLASS_W   (CLASS_W),
      .INDEX_W   (INDEX_W),
      .MSG_CLASS (CLS_COMPLETER),
      .MSG_INDEX (IDX_INT_ABORT)
   ) msg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .err_i   (split_hit),
      .ack_i   (msg_ack_i),
      .init_o  (msg_init),
      .req_o   (msg_req_o),
      .class_o (msg_class_o),
      .index_o (msg_index_o)
   );

   for (genvar s = 0; s < STAT_W; s++) begin : g_stat_set
      if (s == TA_BIT) begin : g_ta
         assign stat_set[s] = ta_set;
      end else begin : g_other
         assign stat_set[s] = 1'b0;
      end
   end

   always_comb begin
      irq_set              = '0;
      irq_set[IRQ_TA_POS]  = ta_set && !mask_ta_i;
      irq_set[IRQ_MSG_POS] = msg_init && !mask_msg_i;
   end

   ibrd_w1c_reg #(.WIDTH(STAT_W)) stat_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (stat_set),
      .clr_i (stat_w1c_i),
      .q_o   (status_o)
   );

   ibrd_w1c_reg #(.WIDTH(IRQ_W)) irq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (irq_set),
      .clr_i (irq_w1c_i),
      .q_o   (irq_stat_o)
   );

endmodule

// File: rtl/ibrd_err_resp_chk.sv
module ibrd_err_resp_chk #(
   parameter int unsigned CLASS_W = 4,
   parameter int unsigned INDEX_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               abort_o,
   input logic               flush_o,
   input logic               cmpl_done_i,
   input logic               msg_req_o,
   input logic               msg_ack_i,
   input logic [CLASS_W-1:0] msg_class_o,
   input logic [INDEX_W-1:0] msg_index_o,
   input logic               ta_stat,
   input logic               irq_ta,
   input logic               irq_msg,
   input logic               mask_ta_i,
   input logic               mask_msg_i
);

   // R2
   abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |=> !abort_o);

   // R4
   abort_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> ta_stat);

   // R5
   ta_irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_ta) |-> $past(!mask_ta_i));

   // R6
   flush_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> $past(cmpl_done_i));

   // R6
   flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> !flush_o);

   // R7
   msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_req_o && !msg_ack_i) |=> (msg_req_o && $stable(msg_class_o) && $stable(msg_index_o)));

   // R7
   msg_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_req_o |-> (msg_class_o == 4'h2 && msg_index_o == 8'h81));

   // R8
   msg_irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_msg) |-> $past(!mask_msg_i));

endmodule

bind ibrd_err_resp ibrd_err_resp_chk #(
   .CLASS_W (ibrd_pkg::CLASS_W),
   .INDEX_W (ibrd_pkg::INDEX_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .abort_o     (abort_o),
   .flush_o     (flush_o),
   .cmpl_done_i (cmpl_done_i),
   .msg_req_o   (msg_req_o),
   .msg_ack_i   (msg_ack_i),
   .msg_class_o (msg_class_o),
   .msg_index_o (msg_index_o),
   .ta_stat     (status_o[TA_BIT]),
   .irq_ta      (irq_stat_o[0]),
   .irq_msg     (irq_stat_o[1]),
   .mask_ta_i   (mask_ta_i),
   .mask_msg_i  (mask_msg_i)
);

// File: tb/ibrd_err_resp_tb_top.sv
module ibrd_err_resp_tb_top;

   localparam int BW = 4;
   localparam int SW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic split_mode = 1'b0, req_start = 1'b0, ib_vld = 1'b0, ib_perr = 1'b0;
   logic [BW-1:0] ib_idx = '0, ret_idx = '0;
   logic ret_vld = 1'b0, cmpl_done = 1'b0, msg_ack = 1'b0;
   logic mask_ta = 1'b0, mask_msg = 1'b0;
   logic [SW-1:0] stat_w1c = '0;
   logic [1:0] irq_w1c = '0;
   logic abort, flush, msg_req;
   logic [3:0] msg_class;
   logic [7:0] msg_index;
   logic [SW-1:0] status;
   logic [1:0] irq_stat;

   int cyc = 0;
   int n_chk = 0;
   int n_err = 0;
   logic prev_msg = 1'b0;

   typedef struct { int kind; int cyc; } ev_t;   // kind: 0 abort, 1 flush, 2 message
   ev_t exp_q[$];

   always #2 clk = ~clk;   // 250 MHz
   always @(posedge clk) cyc <= cyc + 1;

   ibrd_err_resp #(.BEAT_W(BW), .STAT_W(SW), .TA_BIT(11)) dut_i (
      .clk(clk), .rst_n(rst_n), .split_mode_i(split_mode), .req_start_i(req_start),
      .ib_vld_i(ib_vld), .ib_idx_i(ib_idx), .ib_perr_i(ib_perr),
      .ret_vld_i(ret_vld), .ret_idx_i(ret_idx), .cmpl_done_i(cmpl_done),
      .msg_ack_i(msg_ack), .mask_ta_i(mask_ta), .mask_msg_i(mask_msg),
      .stat_w1c_i(stat_w1c), .irq_w1c_i(irq_w1c),
      .abort_o(abort), .flush_o(flush), .msg_req_o(msg_req),
      .msg_class_o(msg_class), .msg_index_o(msg_index),
      .status_o(status), .irq_stat_o(irq_stat)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic string kind_req(input int k);
      return (k == 0) ? "R2" : (k == 1) ? "R6" : "R7";
   endfunction

   task automatic expect_ev(input int k);
      ev_t e;
      e.kind = k;
      e.cyc  = cyc + 1;
      exp_q.push_back(e);
   endtask

   task automatic seen_ev(input int k);
      ev_t e;
      n_chk++;
      if (exp_q.size() == 0) begin
         n_err++;
         $display("FAIL %s: actual unexpected event %0d expected none (cycle %0d)", kind_req(k), k, cyc);
      end else begin
         e = exp_q.pop_front();
         if (e.kind != k || e.cyc != cyc) begin
            n_err++;
            $display("FAIL %s: actual event %0d at cycle %0d expected event %0d at cycle %0d",
                     kind_req(k), k, cyc, e.kind, e.cyc);
         end
      end
   endtask

   // monitor: pops expected events as the design produces them
   always @(negedge clk) begin
      if (rst_n) begin
         if (abort) seen_ev(0);
         if (flush) seen_ev(1);
         if (msg_req && !prev_msg) seen_ev(2);
         prev_msg <= msg_req;
      end
   end

   task automatic tick;
      @(posedge clk);
      #1;
      req_start = 0; ib_vld = 0; ib_perr = 0; ret_vld = 0;
      cmpl_done = 0; msg_ack = 0; stat_w1c = '0; irq_w1c = '0;
   endtask

   task automatic start_req;
      req_start = 1;
      tick();
   endtask

   task automatic ib_beat(input int idx, input bit perr, input bit exp_msg);
      ib_vld = 1; ib_idx = BW'(idx); ib_perr = perr;
      if (exp_msg) expect_ev(2);
      tick();
   endtask

   task automatic ret_beat(input int idx, input bit exp_abort);
      ret_vld = 1; ret_idx = BW'(idx);
      if (exp_abort) expect_ev(0);
      tick();
   endtask

   task automatic finish_req(input bit exp_flush);
      cmpl_done = 1;
      if (exp_flush) expect_ev(1);
      tick();
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) tick();
      // R1 reset state
      check("R1 abort", 32'(abort), 0);
      check("R1 flush", 32'(flush), 0);
      check("R1 msg", {msg_req, msg_class, msg_index}, 0);
      check("R1 status", 32'(status), 0);
      check("R1 irq", 32'(irq_stat), 0);
      rst_n = 1;
      tick();

      // R11 clean conventional request
      start_req();
      for (int i = 0; i < 4; i++) ib_beat(i, 0, 0);
      for (int i = 0; i < 4; i++) ret_beat(i, 0);
      finish_req(0);
      tick();
      check("R11 status", 32'(status), 0);
      check("R11 irq", 32'(irq_stat), 0);

      // R2/R3/R4/R5/R6 two bad beats, abort on the first one only
      start_req();
      ib_beat(0, 0, 0); ib_beat(1, 0, 0); ib_beat(2, 1, 0); ib_beat(3, 1, 0);
      ret_beat(0, 0); ret_beat(1, 0);
      check("R2 no early abort", 32'(abort), 0);
      ret_beat(2, 1);
      check("R2 abort", 32'(abort), 1);
      check("R4 status bit 11", 32'(status), 32'h0800);
      check("R5 irq ta unmasked", 32'(irq_stat), 1);
      ret_beat(3, 0);   // R3 second bad beat ignored
      check("R3 no second abort", 32'(abort), 0);
      finish_req(1);
      check("R6 flush", 32'(flush), 1);
      tick();
      check("R6 flush single", 32'(flush), 0);

      // R10 write-one-to-clear
      stat_w1c = 16'h0800; irq_w1c = 2'b01;
      tick();
      check("R10 status clear", 32'(status), 0);
      check("R10 irq clear", 32'(irq_stat), 0);

      // R5/R10 masked abort, clear strobe on the abort cycle
      mask_ta = 1;
      start_req();
      ib_beat(0, 1, 0);
      stat_w1c = 16'h0800;
      ret_beat(0, 1);
      check("R10 set beats clear", 32'(status), 32'h0800);
      check("R5 irq ta masked", 32'(irq_stat), 0);
      finish_req(1);
      tick();
      mask_ta = 0;
      stat_w1c = 16'h0800;
      tick();

      // R7/R8/R9 split mode message
      split_mode = 1;
      start_req();
      ib_beat(1, 1, 1);
      check("R7 msg raised", 32'(msg_req), 1);
      check("R7 msg code", {msg_class, msg_index}, 12'h281);
      check("R8 irq msg", 32'(irq_stat), 2);
      ib_beat(2, 1, 0);   // R9 ignored while pending
      tick(); tick();
      check("R7 msg held", {msg_req, msg_class, msg_index}, 13'h1281);
      msg_ack = 1;
      tick();
      check("R7 msg dropped", 32'(msg_req), 0);
      tick();
      check("R9 no second msg", 32'(msg_req), 0);
      ret_beat(1, 0); ret_beat(2, 0);
      finish_req(0);
      tick();
      check("R7 no abort status", 32'(status), 0);

      // R8 masked message interrupt
      irq_w1c = 2'b10;
      tick();
      mask_msg = 1;
      start_req();
      ib_beat(0, 1, 1);
      check("R8 msg masked irq", 32'(irq_stat), 0);
      check("R7 masked msg raised", 32'(msg_req), 1);
      msg_ack = 1;
      tick();
      finish_req(0);
      repeat (4) tick();

      n_chk++;
      if (exp_q.size() != 0) begin
         n_err++;
         $display("FAIL R2/R6/R7 events: actual %0d missing expected 0", exp_q.size());
      end
      summary();
      $finish;
   end

endmodule